// File: doc/BRIEF.md
# Packet Ingress Buffer with Route Lookup

This block sits on one input of a packet switch. Incoming stream packets are written into a word buffer. The stream identifier is taken from the first word of every packet at a configurable bit position and handed to an external routing table over a find channel. The table answers on a separate result channel, whenever it is ready, with a port index and a hit flag.

Each packet is held in the buffer until the answer for that packet has been accepted. The packet then leaves with the destination port and the hit flag attached to every one of its words. When the table reports a miss, the destination is replaced by a fixed default port. Answers are paired with packets strictly in arrival order. Two small queues sit between header capture and egress: one holds identifiers that are waiting to be issued, and one holds answers that are waiting for their packet.

Top module: `pkt_route_ingress`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` and `find_valid` are 0, and `in_ready` is 1.
- R2: `find_id` equals bits `ID_LSB` to `ID_LSB+ID_W-1` of the first word of the oldest packet whose lookup has not yet been issued.
- R3: Exactly one find is issued per packet, in packet arrival order. Words that are not the first word of a packet never cause a find.
- R4: No word of a packet is presented on the output until its first word is in the buffer and a result for that packet has been accepted on the result channel.
- R5: `out_dest` and `out_hit` are the same on every word of a packet, from the first word through the word with `out_last`=1.
- R6: A result with hit=1 gives `out_hit`=1 and `out_dest` equal to the returned port. A result with hit=0 gives `out_hit`=0 and `out_dest`=`DEF_PORT`.
- R7: The buffer holds 2^`DEPTH_LOG2` words. When it is full, `in_ready` is 0. No accepted word is lost, and words leave in the order they arrived, with their `in_last` flag carried to `out_last`.
- R8: `res_ready` is 0 exactly when 2^`HQ_LOG2` accepted results are waiting for their packets.
- R9: Once `find_valid` is 1, it stays 1 with an unchanged `find_id` until `find_ready` is 1.
- R10: When 2^`HQ_LOG2` identifiers are waiting to be issued, `in_ready` is 0 for a word that would start a packet. Words in the middle of a packet are still accepted while buffer space remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Incoming packet word |
| in_last | input | 1 | Last word of the incoming packet |
| in_valid | input | 1 | Incoming word valid |
| in_ready | output | 1 | Block can take the incoming word |
| out_data | output | DATA_W | Outgoing packet word |
| out_dest | output | PORT_W | Destination port of the outgoing packet |
| out_hit | output | 1 | 1 when the lookup for this packet hit |
| out_last | output | 1 | Last word of the outgoing packet |
| out_valid | output | 1 | Outgoing word valid |
| out_ready | input | 1 | Downstream takes the outgoing word |
| find_id | output | ID_W | Identifier sent to the routing table |
| find_valid | output | 1 | Find request valid |
| find_ready | input | 1 | Routing table takes the find request |
| res_port | input | PORT_W | Port index returned by the table |
| res_hit | input | 1 | Table found the identifier |
| res_valid | input | 1 | Result valid |
| res_ready | output | 1 | Block takes the result |

## Verification
The hardest situations to reach are those where several limits act at once. These include a full buffer while results are still queued, an identifier queue that is full while a packet is partly received, and a result queue that fills because first words cannot drain. The stimulus cycles through phases that starve one channel at a time: the output, the result channel, or the find channel. This holds each queue at its limit for many cycles. A behavioural model made of queues predicts every ready, valid and payload on every clock, so each stall and release edge is checked in the cycle where it happens.

// File: rtl/pri_pkg.sv
package pri_pkg;

  typedef enum logic {EG_HEAD = 1'b0, EG_BODY = 1'b1} eg_state_t;

  // Start-of-packet tracking: after an accepted word, the next word is a
  // header exactly when the accepted word closed its packet.
  function automatic logic next_sof(input logic cur, input logic fire, input logic last);
    return fire ? last : cur;
  endfunction

endpackage

// File: rtl/pri_fifo.sv
module pri_fifo #(
  parameter int W    = 8,
  parameter int LOG2 = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int DEPTH = 1 << LOG2;

  logic [W-1:0] mem [DEPTH];
  logic [LOG2:0] wp, rp;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push_i) wp <= wp + 1'b1;
      if (pop_i)  rp <= rp + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wp[LOG2-1:0]] <= din_i;
  end

  assign dout_o  = mem[rp[LOG2-1:0]];
  assign empty_o = (wp == rp);
  assign full_o  = (wp[LOG2] != rp[LOG2]) && (wp[LOG2-1:0] == rp[LOG2-1:0]);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push_i |-> !full_o); // R7
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop_i |-> !empty_o); // R7

endmodule

// File: rtl/pri_egress.sv
module pri_egress
  import pri_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int PORT_W   = 3,
  parameter int DEF_PORT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              buf_empty_i,
  input  logic [DATA_W:0]   buf_word_i,
  input  logic              rq_empty_i,
  input  logic [PORT_W-1:0] rq_port_i,
  input  logic              rq_hit_i,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [PORT_W-1:0] out_dest_o,
  output logic              out_hit_o,
  output logic              out_last_o,
  output logic              buf_pop_o,
  output logic              rq_pop_o
);
  localparam logic [PORT_W-1:0] DEF_SEL = PORT_W'(DEF_PORT);

  function automatic logic [PORT_W-1:0] route_of(input logic hit, input logic [PORT_W-1:0] p);
    return hit ? p : DEF_SEL;
  endfunction

  eg_state_t         st;
  logic [PORT_W-1:0] dest_q;
  logic              hit_q;
  logic              head_ok;
  logic              eg_fire;
  logic              eg_first;

  assign head_ok     = (st == EG_BODY) || !rq_empty_i;
  assign out_valid_o = !buf_empty_i && head_ok;
  assign out_data_o  = buf_word_i[DATA_W-1:0];
  assign out_last_o  = buf_word_i[DATA_W];
  assign out_dest_o  = (st == EG_BODY) ? dest_q : route_of(rq_hit_i, rq_port_i);
  assign out_hit_o   = (st == EG_BODY) ? hit_q : rq_hit_i;

  assign eg_fire   = out_valid_o && out_ready_i;
  assign eg_first  = eg_fire && (st == EG_HEAD);
  assign buf_pop_o = eg_fire;
  assign rq_pop_o  = eg_first;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= EG_HEAD;
      dest_q <= '0;
      hit_q  <= 1'b0;
    end else if (eg_fire) begin
      if (st == EG_HEAD) begin
        dest_q <= out_dest_o;
        hit_q  <= out_hit_o;
      end
      st <= out_last_o ? EG_HEAD : EG_BODY;
    end
  end

  AST_DEST_STABLE: assert property (@(posedge clk) disable iff (rst)
    (st == EG_BODY && $past(st == EG_BODY)) |-> ($stable(out_dest_o) && $stable(out_hit_o))); // R5
  AST_RESULT_PER_HEAD: assert property (@(posedge clk) disable iff (rst)
    rq_pop_o |=> (st == EG_BODY) || $past(out_last_o)); // R3

endmodule

// File: rtl/pkt_route_ingress.sv
module pkt_route_ingress
  import pri_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int DEPTH_LOG2 = 9,
  parameter int ID_LSB     = 0,
  parameter int ID_W       = 16,
  parameter int NPORTS     = 8,
  parameter int DEF_PORT   = 0,
  parameter int HQ_LOG2    = 2,
  localparam int PORT_W    = $clog2(NPORTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [PORT_W-1:0] out_dest,
  output logic              out_hit,
  output logic              out_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   find_id,
  output logic              find_valid,
  input  logic              find_ready,
  input  logic [PORT_W-1:0] res_port,
  input  logic              res_hit,
  input  logic              res_valid,
  output logic              res_ready
);
  function automatic logic [ID_W-1:0] id_of(input logic [DATA_W-1:0] w);
    logic [DATA_W-1:0] s;
    s = w >> ID_LSB;
    return s[ID_W-1:0];
  endfunction

  // Named internal events
  logic              sof;
  logic              in_fire;
  logic              hdr_push;
  logic              find_fire;
  logic              res_fire;
  logic              dfull, dempty;
  logic              hfull, hempty;
  logic              rfull, rempty;
  logic [DATA_W:0]   dword;
  logic [PORT_W:0]   rword;
  logic              buf_pop, rq_pop;

  assign in_ready  = !dfull && !(sof && hfull);
  assign in_fire   = in_valid && in_ready;
  assign hdr_push  = in_fire && sof;
  assign find_valid = !hempty;
  assign find_fire = find_valid && find_ready;
  assign res_ready = !rfull;
  assign res_fire  = res_valid && res_ready;

  always_ff @(posedge clk) begin
    if (rst) sof <= 1'b1;
    else     sof <= next_sof(sof, in_fire, in_last);
  end

  pri_fifo #(.W(DATA_W + 1), .LOG2(DEPTH_LOG2)) u_data (
    .clk(clk), .rst(rst),
    .push_i(in_fire), .din_i({in_last, in_data}),
    .pop_i(buf_pop), .dout_o(dword),
    .full_o(dfull), .empty_o(dempty)
  );

  pri_fifo #(.W(ID_W), .LOG2(HQ_LOG2)) u_hdr (
    .clk(clk), .rst(rst),
    .push_i(hdr_push), .din_i(id_of(in_data)),
    .pop_i(find_fire), .dout_o(find_id),
    .full_o(hfull), .empty_o(hempty)
  );

  pri_fifo #(.W(PORT_W + 1), .LOG2(HQ_LOG2)) u_res (
    .clk(clk), .rst(rst),
    .push_i(res_fire), .din_i({res_hit, res_port}),
    .pop_i(rq_pop), .dout_o(rword),
    .full_o(rfull), .empty_o(rempty)
  );

  pri_egress #(.DATA_W(DATA_W), .PORT_W(PORT_W), .DEF_PORT(DEF_PORT)) u_eg (
    .clk(clk), .rst(rst),
    .buf_empty_i(dempty), .buf_word_i(dword),
    .rq_empty_i(rempty), .rq_port_i(rword[PORT_W-1:0]), .rq_hit_i(rword[PORT_W]),
    .out_ready_i(out_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_dest_o(out_dest),
    .out_hit_o(out_hit), .out_last_o(out_last),
    .buf_pop_o(buf_pop), .rq_pop_o(rq_pop)
  );

  AST_FIND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (find_valid && !find_ready) |=> (find_valid && $stable(find_id))); // R9
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (rst)
    dfull |-> !in_ready); // R7
  AST_MISS_DEFAULT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_hit) |-> (out_dest == PORT_W'(DEF_PORT))); // R6
  AST_GATED_HEAD: assert property (@(posedge clk) disable iff (rst)
    rq_pop |-> (buf_pop && !rempty)); // R4

endmodule

// File: tb/pkt_route_ingress_bench.sv
module pkt_route_ingress_bench;
  localparam int DATA_W = 16;
  localparam int DLOG   = 3;
  localparam int ID_LSB = 4;
  localparam int ID_W   = 6;
  localparam int NP     = 4;
  localparam int PW     = 2;
  localparam int DEFP   = 2;
  localparam int HLOG   = 1;
  localparam int DCAP   = 1 << DLOG;
  localparam int QCAP   = 1 << HLOG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DATA_W-1:0] in_data = '0;
  logic in_last = 1'b0, in_valid = 1'b0, in_ready;
  logic [DATA_W-1:0] out_data;
  logic [PW-1:0] out_dest;
  logic out_hit, out_last, out_valid;
  logic out_ready = 1'b0;
  logic [ID_W-1:0] find_id;
  logic find_valid;
  logic find_ready = 1'b0;
  logic [PW-1:0] res_port = '0;
  logic res_hit = 1'b0, res_valid = 1'b0, res_ready;

  always #2 clk = ~clk;

  pkt_route_ingress #(.DATA_W(DATA_W), .DEPTH_LOG2(DLOG), .ID_LSB(ID_LSB), .ID_W(ID_W),
                      .NPORTS(NP), .DEF_PORT(DEFP), .HQ_LOG2(HLOG)) u_pkt_route_ingress (
    .clk(clk), .rst(rst),
    .in_data(in_data), .in_last(in_last), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_dest(out_dest), .out_hit(out_hit), .out_last(out_last),
    .out_valid(out_valid), .out_ready(out_ready),
    .find_id(find_id), .find_valid(find_valid), .find_ready(find_ready),
    .res_port(res_port), .res_hit(res_hit), .res_valid(res_valid), .res_ready(res_ready)
  );

  int nvec = 0, nerr = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Reference model state
  logic [DATA_W:0] bq[$];
  int hq[$];
  logic [PW:0] rq[$];
  int lk[$];
  bit m_sof = 1'b1, m_body = 1'b0;
  logic [PW-1:0] m_dest = '0;
  bit m_hit = 1'b0;

  // Stimulus state
  int pkt_left = 1;
  bit in_head = 1'b1;
  int p_in, p_out, p_res, p_find;
  int idle = 0;

  function automatic logic [DATA_W-1:0] make_word(input bit hdr);
    logic [DATA_W-1:0] w;
    w = DATA_W'($urandom);
    if (hdr) w[ID_LSB +: ID_W] = ID_W'($urandom);
    return w;
  endfunction

  function automatic bit roll(input int pct);
    return ($urandom % 100) < pct;
  endfunction

  initial begin
    bit e_inr, e_outv, e_fv, e_rr;
    bit f_in, f_out, f_find, f_res;
    logic [PW-1:0] e_dest;
    bit e_hit;
    int ph;
    // R1: reset state, while reset is held
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid in reset", int'(out_valid), 0);
    chk("R1", "find_valid in reset", int'(find_valid), 0);
    chk("R1", "in_ready in reset", int'(in_ready), 1);
    @(posedge clk); #1;
    rst = 1'b0;
    in_data = make_word(1'b1);
    pkt_left = 1 + ($urandom % 5);
    in_last = (pkt_left == 1);
    for (int cyc = 0; cyc < 6000; cyc++) begin
      ph = (cyc / 500) % 4;
      case (ph)
        0: begin p_in = 70; p_out = 70; p_res = 60; p_find = 70; end
        1: begin p_in = 90; p_out = 5;  p_res = 90; p_find = 90; end
        2: begin p_in = 80; p_out = 80; p_res = 5;  p_find = 80; end
        default: begin p_in = 80; p_out = 60; p_res = 60; p_find = 3; end
      endcase
      @(negedge clk);
      // expected outputs
      e_inr  = (bq.size() < DCAP) && !(m_sof && hq.size() == QCAP);
      e_fv   = (hq.size() > 0);
      e_rr   = (rq.size() < QCAP);
      e_outv = (bq.size() > 0) && (m_body || rq.size() > 0);
      chk((cyc == 0) ? "R1" : "R7/R10", "in_ready", int'(in_ready), int'(e_inr));
      chk((cyc == 0) ? "R1" : "R3", "find_valid", int'(find_valid), int'(e_fv));
      chk("R8", "res_ready", int'(res_ready), int'(e_rr));
      chk((cyc == 0) ? "R1" : "R4", "out_valid", int'(out_valid), int'(e_outv));
      if (e_fv) chk("R2", "find_id", int'(find_id), hq[0]);
      if (e_outv) begin
        if (m_body) begin
          e_dest = m_dest; e_hit = m_hit;
        end else begin
          e_hit  = rq[0][PW];
          e_dest = e_hit ? rq[0][PW-1:0] : PW'(DEFP);
        end
        chk("R7", "out_data", int'(out_data), int'(bq[0][DATA_W-1:0]));
        chk("R7", "out_last", int'(out_last), int'(bq[0][DATA_W]));
        chk(m_body ? "R5" : "R6", "out_dest", int'(out_dest), int'(e_dest));
        chk(m_body ? "R5" : "R6", "out_hit", int'(out_hit), int'(e_hit));
      end
      // model update
      f_in   = in_valid && e_inr;
      f_out  = e_outv && out_ready;
      f_find = e_fv && find_ready;
      f_res  = res_valid && e_rr;
      if (f_out) begin
        if (!m_body) begin
          m_dest = e_dest; m_hit = e_hit;
          void'(rq.pop_front());
        end
        m_body = !bq[0][DATA_W];
        void'(bq.pop_front());
        idle = 0;
      end else idle++;
      if (f_find) lk.push_back(hq.pop_front());
      if (f_res) begin
        rq.push_back({res_hit, res_port});
        void'(lk.pop_front());
      end
      if (f_in) begin
        bq.push_back({in_last, in_data});
        if (m_sof) hq.push_back(int'(in_data[ID_LSB +: ID_W]));
        m_sof = in_last;
      end
      if (idle > 1500) begin
        chk("R4", "watchdog progress", 0, 1);
        break;
      end
      // next stimulus
      @(posedge clk); #1;
      if (f_in) begin
        pkt_left--;
        in_head = (pkt_left == 0);
        if (in_head) pkt_left = 1 + ($urandom % 5);
        in_data = make_word(in_head);
        in_last = (pkt_left == 1);
        in_valid = roll(p_in);
      end else if (!in_valid) begin
        in_valid = roll(p_in);
      end
      out_ready  = roll(p_out);
      find_ready = roll(p_find);
      if (f_res) res_valid = 1'b0;
      if (!res_valid && lk.size() > (f_res ? 0 : 0) && roll(p_res)) begin
        res_valid = 1'b1;
        res_port  = PW'(lk[0]);
        res_hit   = (lk[0] % 3) != 0;
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule